// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides a fast input clock by N = B·P + A, where P is the lower modulus of a dual-modulus prescaler (P/P+1). A swallow counter holds the prescaler at P+1 for the first A prescaler periods of every output cycle. After that the prescaler runs at P until the main counter has seen B prescaler periods in total. One single-cycle pulse is emitted per N input clocks.

The prescaler is modelled behaviourally inside the input clock domain. It counts input clocks and marks the last clock of each of its periods. The parameter `HIGH_BAND` picks the prescaler family. A one-bit port then picks the pair within that family. A, B and the pair select are sampled only at a reload boundary. A setting with A greater than B, or with B equal to zero, raises a sticky error flag and parks the divider until reset.

Top module: `psw_divider`

## Requirements
- R1: With a valid setting, consecutive `div_pulse` assertions are exactly N = B·P + A input clocks apart. The first pulse comes N clocks after the first clock edge that follows reset release.
- R2: With `HIGH_BAND` = 0, `p_sel` = 0 gives P = 8 (8/9 prescaler) and `p_sel` = 1 gives P = 16 (16/17 prescaler).
- R3: With `HIGH_BAND` = 1, `p_sel` = 0 gives P = 64 (64/65 prescaler) and `p_sel` = 1 gives P = 32 (32/33 prescaler).
- R4: Within each output cycle, `mod_hi` is 1 for the first A·(P+1) input clocks (prescaler at P+1). It is 0 for the remaining (B−A)·P clocks and never returns to 1 before the next reload.
- R5: With A = 0 the ratio is exactly B·P, and `mod_hi` stays 0.
- R6: If A > B at a reload boundary, `cfg_err` rises and stays at 1 until `rst`. While it is set, `div_pulse` and `mod_hi` stay 0, whatever later happens on `a_val`, `b_val` and `p_sel`.
- R7: B = 0 at a reload boundary is treated like R6: `cfg_err` rises and the divider stays parked.
- R8: Changes on `a_val`, `b_val` and `p_sel` in the middle of an output cycle do not alter that cycle's length. They take effect from the next reload boundary, which is the clock edge that raises `div_pulse`.
- R9: While `rst` is high, `div_pulse`, `mod_hi` and `cfg_err` are 0.
- R10: `div_pulse` is high for exactly one input clock per output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| a_val | input | A_W (6) | Swallow count A, 0 to 63 |
| b_val | input | B_W (11) | Main count B, 1 to 2047 |
| p_sel | input | 1 | Prescaler pair select within the band |
| div_pulse | output | 1 | One-clock pulse per N input clocks |
| mod_hi | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| cfg_err | output | 1 | Sticky flag for an invalid A/B setting |

## Verification
The bench builds two copies of the divider with the default counter widths (6-bit A, 11-bit B). One copy uses `HIGH_BAND` = 0 and the other uses `HIGH_BAND` = 1, so all four prescaler pairs (8, 16, 32, 64) are reached from the shared `p_sel` input. Both copies are driven through A = 0, A = B, the largest A, mid-cycle setting changes, and both invalid settings with recovery through reset. The B values are kept small, so each run covers many full output cycles even at P = 64.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int MOD_W = 7;
  typedef logic [MOD_W-1:0] modulus_t;

  // lower modulus P of the selected prescaler pair
  function automatic modulus_t pair_low(input bit high_band, input logic sel);
    if (high_band) return sel ? modulus_t'(32) : modulus_t'(64);
    return sel ? modulus_t'(16) : modulus_t'(8);
  endfunction
endpackage

// File: rtl/psw_cfg_check.sv
module psw_cfg_check #(
  parameter int A_W = 6,
  parameter int B_W = 11,
  parameter bit HIGH_BAND = 1'b0
) (
  input  logic [A_W-1:0]        a_in,
  input  logic [B_W-1:0]        b_in,
  input  logic                  sel,
  output logic                  ok,
  output psw_pkg::modulus_t     p_new
);
  localparam int PAD_W = B_W - A_W;

  logic [B_W-1:0] a_wide;

  generate
    if (PAD_W > 0) begin : g_pad
      assign a_wide = {{PAD_W{1'b0}}, a_in};
    end else begin : g_nopad
      assign a_wide = B_W'(a_in);
    end
  endgenerate

  assign ok    = (b_in != '0) && (a_wide <= b_in);
  assign p_new = psw_pkg::pair_low(HIGH_BAND, sel);
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              hi_next,
  input  psw_pkg::modulus_t p_next,
  output logic              tick
);
  psw_pkg::modulus_t pc;

  assign tick = run && (pc == '0);

  // pc counts the input clocks left in the current prescaler period
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (restart || tick) begin
      pc <= hi_next ? p_next : p_next - psw_pkg::modulus_t'(1);
    end else if (run) begin
      pc <= pc - psw_pkg::modulus_t'(1);
    end
  end

  // R1: prescaler periods last at least P >= 8 clocks
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R1: the period count never exceeds the active modulus
  p_pc_range_r1: assert property (@(posedge clk) disable iff (rst)
    (run && !restart) |-> (pc <= p_next));
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           tick,
  output logic           mod_ctl,
  output logic           mod_next,
  output logic           last
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem <= '0;
      b_rem <= '0;
    end else if (load) begin
      a_rem <= a_in;
      b_rem <= b_in;
    end else if (tick) begin
      a_rem <= (a_rem != '0) ? a_rem - 1'b1 : '0;
      b_rem <= b_rem - 1'b1;
    end
  end

  assign mod_ctl  = (a_rem != '0);
  assign mod_next = (a_rem > A_W'(1));
  assign last     = (b_rem == B_W'(1));

  // R4: once at P, the modulus stays at P until the next reload
  p_swallow_order_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !mod_ctl) |=> !mod_ctl);

  // R6: the swallow count never runs ahead of the main count
  p_a_within_b_r6: assert property (@(posedge clk) disable iff (rst)
    (B_W'(a_rem) <= b_rem));
endmodule

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int A_W = 6,
  parameter int B_W = 11,
  parameter bit HIGH_BAND = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           p_sel,
  output logic           div_pulse,
  output logic           mod_hi,
  output logic           cfg_err
);
  import psw_pkg::*;

  logic     run;
  modulus_t cur_p;
  modulus_t p_new;
  modulus_t p_next;
  logic     cfg_ok;
  logic     load;
  logic     load_ok;
  logic     hi_next;
  logic     tick;
  logic     mod_ctl;
  logic     mod_next;
  logic     last;

  psw_cfg_check #(.A_W(A_W), .B_W(B_W), .HIGH_BAND(HIGH_BAND)) cfg_i (
    .a_in (a_val),
    .b_in (b_val),
    .sel  (p_sel),
    .ok   (cfg_ok),
    .p_new(p_new)
  );

  // reload boundary: first start after reset, or last clock of a cycle
  assign load    = (!run && !cfg_err) || (tick && last);
  assign load_ok = load && cfg_ok;
  assign hi_next = load ? (a_val != '0) : mod_next;
  assign p_next  = load ? p_new : cur_p;

  psw_prescaler pre_i (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .restart(load_ok),
    .hi_next(hi_next),
    .p_next (p_next),
    .tick   (tick)
  );

  psw_swallow #(.A_W(A_W), .B_W(B_W)) swl_i (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ok),
    .a_in    (a_val),
    .b_in    (b_val),
    .tick    (tick),
    .mod_ctl (mod_ctl),
    .mod_next(mod_next),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      cfg_err   <= 1'b0;
      cur_p     <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= tick && last;
      if (load) begin
        if (cfg_ok) begin
          run   <= 1'b1;
          cur_p <= p_new;
        end else begin
          run     <= 1'b0;
          cfg_err <= 1'b1;
        end
      end
    end
  end

  assign mod_hi = run && mod_ctl;

  // R6: error flag is sticky until reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R6: a parked divider emits nothing
  p_err_silent_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> (!div_pulse && !mod_hi));

  // R10: output pulse lasts one clock
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R8: the active modulus changes only at a reload boundary
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(cur_p));
endmodule

// File: tb/psw_divider_tb_top.sv
module psw_ref_model #(
  parameter bit HB = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  a,
  input  logic [10:0] b,
  input  logic        sel,
  output logic        exp_pulse,
  output logic        exp_mod,
  output logic        exp_err
);
  integer cnt, pos, ma, mp;
  bit     run, reload;

  function automatic int pval(input logic s);
    if (HB) return s ? 32 : 64;
    return s ? 16 : 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      run = 0; exp_err = 0; exp_pulse = 0;
      cnt = 0; pos = 0; ma = 0; mp = 0;
    end else begin
      exp_pulse = 0;
      reload = 0;
      if (run) begin
        cnt = cnt - 1;
        pos = pos + 1;
        if (cnt == 0) begin
          exp_pulse = 1;
          reload = 1;
        end
      end else if (!exp_err) begin
        reload = 1;
      end
      if (reload) begin
        if (int'(b) == 0 || int'(a) > int'(b)) begin
          run = 0;
          exp_err = 1;
        end else begin
          run = 1;
          ma  = int'(a);
          mp  = pval(sel);
          cnt = int'(b) * mp + int'(a);
          pos = 0;
        end
      end
    end
    exp_mod = run && (pos < ma * (mp + 1));
  end
endmodule

module psw_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  a_val = 6'd3;
  logic [10:0] b_val = 11'd10;
  logic        p_sel = 1'b0;

  logic lo_pulse, lo_mod, lo_err;
  logic hi_pulse, hi_mod, hi_err;
  logic elo_pulse, elo_mod, elo_err;
  logic ehi_pulse, ehi_mod, ehi_err;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    lo_seen = 0;
  int    hi_seen = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  psw_divider #(.A_W(6), .B_W(11), .HIGH_BAND(1'b0)) dut_i (
    .clk(clk), .rst(rst), .a_val(a_val), .b_val(b_val), .p_sel(p_sel),
    .div_pulse(lo_pulse), .mod_hi(lo_mod), .cfg_err(lo_err));

  psw_divider #(.A_W(6), .B_W(11), .HIGH_BAND(1'b1)) dut_hb (
    .clk(clk), .rst(rst), .a_val(a_val), .b_val(b_val), .p_sel(p_sel),
    .div_pulse(hi_pulse), .mod_hi(hi_mod), .cfg_err(hi_err));

  psw_ref_model #(.HB(1'b0)) ref_lo (
    .clk(clk), .rst(rst), .a(a_val), .b(b_val), .sel(p_sel),
    .exp_pulse(elo_pulse), .exp_mod(elo_mod), .exp_err(elo_err));

  psw_ref_model #(.HB(1'b1)) ref_hi (
    .clk(clk), .rst(rst), .a(a_val), .b(b_val), .sel(p_sel),
    .exp_pulse(ehi_pulse), .exp_mod(ehi_mod), .exp_err(ehi_err));

  task automatic check_eq(input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic run_clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (chk_en) begin
      check_eq({cur_req, " R1/R10 pulse band0"}, int'(lo_pulse), int'(elo_pulse));
      check_eq({cur_req, " R1/R10 pulse band1"}, int'(hi_pulse), int'(ehi_pulse));
      check_eq({cur_req, " R4 modulus band0"}, int'(lo_mod), int'(elo_mod));
      check_eq({cur_req, " R4 modulus band1"}, int'(hi_mod), int'(ehi_mod));
      check_eq({cur_req, " R6/R7 error band0"}, int'(lo_err), int'(elo_err));
      check_eq({cur_req, " R6/R7 error band1"}, int'(hi_err), int'(ehi_err));
      if (lo_pulse) lo_seen++;
      if (hi_pulse) hi_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic expect_live(input string req);
    check_eq({req, " pulses seen band0"}, int'(lo_seen > 0), 1);
    check_eq({req, " pulses seen band1"}, int'(hi_seen > 0), 1);
    lo_seen = 0;
    hi_seen = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    run_clocks(3);
    rst = 1'b0;
    lo_seen = 0;
    hi_seen = 0;
  endtask

  initial begin
    @(posedge clk);
    @(negedge clk);
    chk_en = 1'b1;
    // R9: outputs idle during reset
    cur_req = "R9";
    run_clocks(4);
    check_eq("R9 reset pulse", int'(lo_pulse | hi_pulse), 0);
    check_eq("R9 reset err", int'(lo_err | hi_err), 0);
    check_eq("R9 reset mod", int'(lo_mod | hi_mod), 0);
    rst = 1'b0;

    // R1/R2/R3: A=3 B=10, p_sel=0 -> P=8 (N=83) and P=64 (N=643)
    cur_req = "R1 R2 R3 sel0";
    run_clocks(2000);
    expect_live("R2 R3 sel0");

    // R2/R3: p_sel=1 -> P=16 (N=163) and P=32 (N=323), changed mid-cycle
    cur_req = "R2 R3 R8 sel1";
    p_sel = 1'b1;
    run_clocks(2000);
    expect_live("R2 R3 sel1");

    // R5: A=0
    cur_req = "R5 A0";
    a_val = 6'd0; b_val = 11'd7; p_sel = 1'b0;
    run_clocks(1500);
    expect_live("R5 A0");
    check_eq("R5 mod stays low band0", int'(lo_mod), 0);

    // R4: A=B boundary
    cur_req = "R4 A=B";
    a_val = 6'd5; b_val = 11'd5;
    run_clocks(2000);
    expect_live("R4 A=B");

    // R8: settings wander mid-cycle
    cur_req = "R8 wander";
    for (int i = 0; i < 60; i++) begin
      b_val = 11'(6 + (i % 5));
      a_val = 6'(i % 6);
      p_sel = i[1];
      run_clocks(37);
    end
    run_clocks(800);
    expect_live("R8 wander");

    // R1: largest swallow count
    cur_req = "R1 maxA";
    a_val = 6'd63; b_val = 11'd63; p_sel = 1'b1;
    run_clocks(5000);
    expect_live("R1 maxA");

    // R6: A > B parks both copies, sticky across later valid settings
    cur_req = "R6 A>B";
    a_val = 6'd9; b_val = 11'd4; p_sel = 1'b0;
    run_clocks(2500);
    check_eq("R6 err band0", int'(lo_err), 1);
    check_eq("R6 err band1", int'(hi_err), 1);
    a_val = 6'd2; b_val = 11'd6;
    lo_seen = 0; hi_seen = 0;
    run_clocks(1000);
    check_eq("R6 sticky err band0", int'(lo_err), 1);
    check_eq("R6 no pulses while parked", lo_seen + hi_seen, 0);
    do_reset();
    cur_req = "R6 recover";
    run_clocks(3);
    check_eq("R6 err cleared by reset", int'(lo_err | hi_err), 0);
    run_clocks(1000);
    expect_live("R6 recover");

    // R7: B = 0
    cur_req = "R7 B0";
    a_val = 6'd0; b_val = 11'd0;
    run_clocks(1000);
    check_eq("R7 err band0", int'(lo_err), 1);
    check_eq("R7 err band1", int'(hi_err), 1);
    do_reset();
    cur_req = "R1 final";
    a_val = 6'd1; b_val = 11'd2; p_sel = 1'b1;
    run_clocks(600);
    expect_live("R1 final");

    finish_run();
  end
endmodule